// File: doc/BRIEF.md
# Window Watchdog with Early Warning

This block supervises software timing with a 7-bit down-counter clocked from the system clock through a two-stage prescaler. Software must refresh the counter by writing its control register inside an allowed window. A refresh that is late lets the counter fall out of its valid range, and the block then issues a one-cycle reset request. A refresh that comes too early, while the count is still above a programmed window value, also issues a reset request.

One step before the late-refresh reset, the block sets an early-warning flag. If enabled, the flag drives an interrupt line, so software gets one last chance to refresh or to save state. Until the watchdog is armed, the counter runs free and can be used as a plain time base without causing a reset. Once armed, only a block reset can disarm it. A debug-freeze input halts both the prescaler and the counter.

Access is through a small register port with three addresses: control, configuration and status. Read data is combinational on the shared address.

Top module: `wdg_window`

## Requirements
- R1: After reset the counter reads 0x7F, the armed bit reads 0, the window reads 0x7F, the prescale select and interrupt enable read 0, and both `irq_o` and `wdg_rst_o` are low.
- R2: A write to CTRL (address 0) loads the counter from `wdata[6:0]` and restarts the prescaler. The counter then decrements by one every `BASE_DIV << sel` clocks, where `sel` is CFG (address 1) bits [8:7]. The first step lands on the `BASE_DIV << sel`-th rising edge after the write edge.
- R3: When the block is armed and the counter steps from 0x40 to 0x3F, `wdg_rst_o` is high for exactly one cycle, registered on that same edge.
- R4: The early-warning flag (STATUS bit 0, address 2) sets on the edge where the counter steps down to 0x40. `irq_o` equals that flag ANDed with CFG bit 9. Writing STATUS with `wdata[0]`=0 clears the flag.
- R5: A CTRL write while armed, with the counter above the window value (CFG bits [6:0]), raises `wdg_rst_o` on the write edge.
- R6: A CTRL write while armed, with the counter at or below the window value, raises no reset.
- R7: While not armed, the counter counts down through 0x40 to 0x3F and `wdg_rst_o` stays low.
- R8: While `dbg_freeze_i` is high, the counter and the prescaler both hold their values. After release, counting resumes from the held prescaler phase.
- R9: CTRL bit 7 arms the watchdog. A later CTRL write with bit 7 clear leaves it armed (CTRL read bit 7 stays 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_freeze_i | input | 1 | Halts prescaler and counter while high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 CTRL, 1 CFG, 2 STATUS |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| irq_o | output | 1 | Early-warning interrupt |
| wdg_rst_o | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach from the ports is the exact edge of the late-refresh reset. That edge depends on the prescaler phase, so the bench always arms the counter with a CTRL write, which restarts the prescaler. It then counts clock edges from that write to expect the warning and the reset on precise cycles. The early-refresh reset needs the armed state to exist before the offending write, so it is reached with two back-to-back CTRL writes. The freeze phase is checked by freezing immediately after a load and counting edges after release.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
    localparam int CNT_W = 7;
    localparam int DATA_W = 16;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CFG = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [CNT_W-1:0] CNT_INIT = 7'h7F;
    localparam logic [CNT_W-1:0] CNT_WARN = 7'h40;
    localparam logic [CNT_W-1:0] CNT_PRE_WARN = 7'h41;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic [CNT_W-1:0] win;
        logic [1:0]       sel;
        logic             ewi_en;
        logic             flag;
        logic             rst;
    } wdw_state_t;
endpackage

// File: rtl/wdw_tick_gen.sv
module wdw_tick_gen #(
    parameter int BASE_DIV = 4096,
    localparam int PRE_W = $clog2(BASE_DIV) + 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       freeze_i,
    input  logic       restart_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit  = (PRE_W'(BASE_DIV) << sel_i) - PRE_W'(1);
        tick_o = !freeze_i && !restart_i && (cnt_q == limit);
        cnt_d  = cnt_q;
        if (restart_i)     cnt_d = '0;
        else if (freeze_i) cnt_d = cnt_q;
        else if (tick_o)   cnt_d = '0;
        else               cnt_d = cnt_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdw_window_chk.sv
module wdw_window_chk
    import wdw_pkg::*;
(
    input  logic             armed_i,
    input  logic             refresh_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] win_i,
    output logic             early_o
);
    always_comb early_o = armed_i && refresh_i && (cnt_i > win_i);
endmodule

// File: rtl/wdg_window.sv
module wdg_window
    import wdw_pkg::*;
#(
    parameter int BASE_DIV = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dbg_freeze_i,
    input  logic        wr_en_i,
    input  logic [1:0]  addr_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    output logic        irq_o,
    output logic        wdg_rst_o
);
    wdw_state_t st_d, st_q;
    logic ctrl_wr, cfg_wr, stat_wr;
    logic tick, early;

    assign ctrl_wr = wr_en_i && (addr_i == ADDR_CTRL);
    assign cfg_wr  = wr_en_i && (addr_i == ADDR_CFG);
    assign stat_wr = wr_en_i && (addr_i == ADDR_STAT);

    wdw_tick_gen #(.BASE_DIV(BASE_DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze_i  (dbg_freeze_i),
        .restart_i (ctrl_wr),
        .sel_i     (st_q.sel),
        .tick_o    (tick)
    );

    wdw_window_chk u_win (
        .armed_i   (st_q.armed),
        .refresh_i (ctrl_wr),
        .cnt_i     (st_q.cnt),
        .win_i     (st_q.win),
        .early_o   (early)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rst = 1'b0;
        if (stat_wr && !wdata_i[0]) st_d.flag = 1'b0;
        if (cfg_wr) begin
            st_d.win    = wdata_i[6:0];
            st_d.sel    = wdata_i[8:7];
            st_d.ewi_en = wdata_i[9];
        end
        if (ctrl_wr) begin
            st_d.cnt   = wdata_i[6:0];
            st_d.armed = st_q.armed | wdata_i[7];
            if (early) st_d.rst = 1'b1;
        end else if (tick) begin
            st_d.cnt = st_q.cnt - 7'd1;
            if (st_q.cnt == CNT_PRE_WARN) st_d.flag = 1'b1;
            if (st_q.cnt == CNT_WARN && st_q.armed) st_d.rst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: CNT_INIT, armed: 1'b0, win: CNT_INIT, sel: 2'd0,
                      ewi_en: 1'b0, flag: 1'b0, rst: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_CTRL: rdata_o = {8'd0, st_q.armed, st_q.cnt};
            ADDR_CFG:  rdata_o = {6'd0, st_q.ewi_en, st_q.sel, st_q.win};
            ADDR_STAT: rdata_o = {15'd0, st_q.flag};
            default:   rdata_o = '0;
        endcase
    end

    assign irq_o     = st_q.flag && st_q.ewi_en;
    assign wdg_rst_o = st_q.rst;
endmodule

// File: rtl/wdg_window_sva.sv
module wdg_window_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       dbg_freeze_i,
    input logic       wr_en_i,
    input logic [1:0] addr_i,
    input logic [6:0] cnt,
    input logic       armed,
    input logic       flag,
    input logic       irq_o,
    input logic       wdg_rst_o
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en_i && (addr_i == 2'd0);

    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - 7'd1));

    assert_reset_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst_o |-> armed);

    assert_flag_at_warn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (cnt == 7'h40));

    assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag);

    assert_freeze_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_freeze_i && !ctrl_wr) |=> $stable(cnt));

    assert_arm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);
endmodule

bind wdg_window wdg_window_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .dbg_freeze_i (dbg_freeze_i),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .cnt          (st_q.cnt),
    .armed        (st_q.armed),
    .flag         (st_q.flag),
    .irq_o        (irq_o),
    .wdg_rst_o    (wdg_rst_o)
);

// File: tb/wdg_window_test.sv
`timescale 1ns/1ps
module wdg_window_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_freeze_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  addr_i = 2'd0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        irq_o, wdg_rst_o;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wdg_window #(.BASE_DIV(4)) uut (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en_i = 1'b0;
        dbg_freeze_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [15:0] d;
        do_reset();
        rd(2'd0, d); chk("R1 ctrl", d, 16'h007F);
        rd(2'd1, d); chk("R1 cfg", d, 16'h007F);
        chk("R1 irq", {15'd0, irq_o}, 16'd0);
        chk("R1 rst", {15'd0, wdg_rst_o}, 16'd0);
    endtask

    task automatic t_prescale();
        logic [15:0] d;
        do_reset();
        wr(2'd1, 16'h017F);        // sel=2 -> step every 16 clocks
        wr(2'd0, 16'h0050);
        wait_neg(15); rd(2'd0, d); chk("R2 before step", d, 16'h0050);
        wait_neg(1);  rd(2'd0, d); chk("R2 step sel2", d, 16'h004F);
    endtask

    task automatic t_late_reset();
        logic [15:0] d;
        do_reset();
        wr(2'd1, 16'h027F);        // irq enabled, window 0x7F, sel 0
        wr(2'd0, 16'h00C2);        // armed, count 0x42
        wait_neg(7);  chk("R4 irq early", {15'd0, irq_o}, 16'd0);
        wait_neg(1);  chk("R4 irq at 0x40", {15'd0, irq_o}, 16'd1);
        rd(2'd2, d);  chk("R4 flag", d, 16'd1);
        wait_neg(3);  chk("R3 no rst yet", {15'd0, wdg_rst_o}, 16'd0);
        wait_neg(1);  chk("R3 rst pulse", {15'd0, wdg_rst_o}, 16'd1);
        wait_neg(1);  chk("R3 rst one cycle", {15'd0, wdg_rst_o}, 16'd0);
        wr(2'd2, 16'h0000);
        chk("R4 irq cleared", {15'd0, irq_o}, 16'd0);
    endtask

    task automatic t_early_refresh();
        do_reset();
        wr(2'd1, 16'h0050);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = 2'd0; wdata_i = 16'h00FF;
        @(negedge clk);
        chk("R5 first arm no rst", {15'd0, wdg_rst_o}, 16'd0);
        @(negedge clk);
        wr_en_i = 1'b0;
        chk("R5 early refresh rst", {15'd0, wdg_rst_o}, 16'd1);
    endtask

    task automatic t_in_window();
        int seen = 0;
        do_reset();
        wr(2'd1, 16'h0050);
        wr(2'd0, 16'h00D0);
        wr(2'd0, 16'h00D0);
        if (wdg_rst_o) seen++;
        wait_neg(2);
        if (wdg_rst_o) seen++;
        chk("R6 in-window no rst", 16'(seen), 16'd0);
    endtask

    task automatic t_free_run();
        logic [15:0] d;
        int seen = 0;
        do_reset();
        wr(2'd0, 16'h0041);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            if (wdg_rst_o) seen++;
        end
        rd(2'd0, d); chk("R7 counter passed", d, 16'h003F);
        chk("R7 no rst", 16'(seen), 16'd0);
    endtask

    task automatic t_freeze();
        logic [15:0] d;
        do_reset();
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = 2'd0; wdata_i = 16'h0045;
        @(negedge clk);
        wr_en_i = 1'b0; dbg_freeze_i = 1'b1;
        wait_neg(40);
        rd(2'd0, d); chk("R8 held", d, 16'h0045);
        dbg_freeze_i = 1'b0;
        wait_neg(3); rd(2'd0, d); chk("R8 phase held", d, 16'h0045);
        wait_neg(1); rd(2'd0, d); chk("R8 resumed", d, 16'h0044);
    endtask

    task automatic t_sticky();
        logic [15:0] d;
        do_reset();
        wr(2'd0, 16'h00FF);
        wr(2'd0, 16'h007F);
        rd(2'd0, d); chk("R9 still armed", {15'd0, d[7]}, 16'd1);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_prescale();
        t_late_reset();
        t_early_refresh();
        t_in_window();
        t_free_run();
        t_freeze();
        t_sticky();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule